// File: doc/BRIEF.md
# Pattern-Fill Write Master

This block is a write-only bus master for bring-up. It writes a counting pattern into a region of memory on a 64-bit processor bus. A register interface supplies three things: a start pulse, a base byte address and a number of words. After the start pulse, the master writes one full 64-bit word per bus transaction. Each transaction uses a request and address-acknowledge phase, followed by a write-data-acknowledge phase. The master repeats this until it has written every word.

Each word carries its own beat index. The upper 32 bits hold the index and the lower 32 bits hold the bitwise complement of the index. A memory dump therefore shows at once which beats landed and where. All transfer attributes are tied off for single, unlocked, non-burst memory writes. An error input from the bus stops the fill and latches an error flag. The flag stays set until the next start pulse.

Top module: `pattern_fill_master`

## Requirements
- R1: The attribute outputs never change. Read-not-write is 0, priority is 2'b11, all eight byte enables are 1, size is 4'b0000 and type is 3'b000. Lock, abort, compress, guarded and ordered are all 0.
- R2: After reset, request, busy, done and error are all 0.
- R3: A start pulse in the idle, done or error state captures the base and the word count. The first request then presents the base address, with beat index 0.
- R4: The request rises one cycle after an accepted start pulse, or one cycle after the previous beat completes. It stays high until address-acknowledge is sampled, and it is low in the following cycle.
- R5: While waiting for write-data-acknowledge of beat k, bits 63:32 of the write data equal k. Bits 31:0 equal ~k.
- R6: Each beat's address is the base plus 8 times its beat index. The address advances by 8 after each write-data-acknowledge.
- R7: After exactly N acknowledged beats, the block raises done and stops requesting. Done stays high until the next start.
- R8: A start with a word count of 0 raises done one cycle later and issues no request.
- R9: Bus error sampled while waiting for either acknowledge ends the fill. The request drops and the error flag stays high until the next accepted start, which clears it. Error takes precedence over an acknowledge in the same cycle.
- R10: A start pulse while a fill is running is ignored. The address sequence and data pattern continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| base_addr_i | input | 32 | First byte address of the region |
| word_count_i | input | 32 | Number of 64-bit words to write |
| addr_ack_i | input | 1 | Address acknowledge from bus |
| wr_ack_i | input | 1 | Write data acknowledge from bus |
| bus_err_i | input | 1 | Bus error |
| bus_req_o | output | 1 | Transfer request |
| bus_prio_o | output | 2 | Request priority |
| bus_rnw_o | output | 1 | Read-not-write |
| bus_be_o | output | 8 | Byte enables |
| bus_size_o | output | 4 | Transfer size code |
| bus_type_o | output | 3 | Transfer type code |
| bus_lock_o | output | 1 | Bus lock |
| bus_abort_o | output | 1 | Abort |
| bus_compress_o | output | 1 | Compressed transfer |
| bus_guarded_o | output | 1 | Guarded transfer |
| bus_ordered_o | output | 1 | Ordered transfer |
| bus_addr_o | output | 32 | Transfer address |
| bus_wdata_o | output | 64 | Write data |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | Fill finished |
| err_o | output | 1 | Fill ended by bus error |

## Verification
The bench holds each acknowledge back for random numbers of cycles. A design that drops the request early, or that advances on the address acknowledge instead of the data acknowledge, then shows a missing beat or a repeated address.

Single-word and zero-word fills target off-by-one termination. A wrong design writes one word too many, or issues a stray request for an empty region.

Errors are injected in both wait phases, including in the same cycle as an acknowledge. A design that lets the acknowledge win keeps writing, and one that fails to latch the flag loses it.

A start pulse is fired mid-fill with a different base. A design that honours it jumps to the wrong address.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_DATA, ST_NEXT, ST_DONE, ST_ERR
  } pfm_state_e;

  localparam logic [1:0] PRIO_TOP   = 2'b11;
  localparam logic [3:0] SIZE_WORD  = 4'b0000;
  localparam logic [2:0] TYPE_MEM   = 3'b000;
endpackage

// File: rtl/pfm_ctrl.sv
module pfm_ctrl
  import pfm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       zero_len_i,
  input  logic       addr_ack_i,
  input  logic       wr_ack_i,
  input  logic       err_i,
  input  logic       last_i,
  output pfm_state_e state_o,
  output logic       load_o,
  output logic       advance_o
);
  pfm_state_e st_q, st_d;
  logic idle_like;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);
  assign load_o    = idle_like && start_i;
  assign advance_o = (st_q == ST_DATA) && wr_ack_i && !err_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_ERR:
        if (start_i) st_d = zero_len_i ? ST_DONE : ST_REQ;
      ST_REQ:
        if (err_i)           st_d = ST_ERR;
        else if (addr_ack_i) st_d = ST_DATA;
      ST_DATA:
        if (err_i)         st_d = ST_ERR;
        else if (wr_ack_i) st_d = ST_NEXT;
      ST_NEXT:
        st_d = last_i ? ST_DONE : ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  AST_ERR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_REQ || st_q == ST_DATA) && err_i) |=> (st_q == ST_ERR)); // R9
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !wr_ack_i && !err_i) |=> (st_q == ST_DATA)); // R10
endmodule

// File: rtl/pfm_beat_ctr.sv
module pfm_beat_ctr #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      total_q <= '0;
    end else if (load_i) begin
      addr_q  <= base_i;
      cnt_q   <= '0;
      total_q <= total_i;
    end else if (advance_i) begin
      addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign addr_o  = addr_q;
  assign count_o = cnt_q;
  assign last_o  = (cnt_q == total_q);

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i) |-> (cnt_q < total_q)); // R7
endmodule

// File: rtl/pfm_data_fmt.sv
module pfm_data_fmt #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [HALF_W-1:0] count_i,
  output logic [DATA_W-1:0] wdata_o
);
  // upper half = index, lower half = its complement
  assign wdata_o = {count_i, ~count_i};
endmodule

// File: rtl/pattern_fill_master.sv
module pattern_fill_master
  import pfm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int CNT_W  = DATA_W / 2,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic              addr_ack_i,
  input  logic              wr_ack_i,
  input  logic              bus_err_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_prio_o,
  output logic              bus_rnw_o,
  output logic [BE_W-1:0]   bus_be_o,
  output logic [3:0]        bus_size_o,
  output logic [2:0]        bus_type_o,
  output logic              bus_lock_o,
  output logic              bus_abort_o,
  output logic              bus_compress_o,
  output logic              bus_guarded_o,
  output logic              bus_ordered_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  pfm_state_e       st;
  logic             load, advance, last;
  logic [CNT_W-1:0] cnt;

  pfm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_len_i (word_count_i == '0),
    .addr_ack_i (addr_ack_i),
    .wr_ack_i   (wr_ack_i),
    .err_i      (bus_err_i),
    .last_i     (last),
    .state_o    (st),
    .load_o     (load),
    .advance_o  (advance)
  );

  pfm_beat_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BE_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .base_i    (base_addr_i),
    .total_i   (word_count_i),
    .advance_i (advance),
    .addr_o    (bus_addr_o),
    .count_o   (cnt),
    .last_o    (last)
  );

  pfm_data_fmt #(.DATA_W(DATA_W)) u_fmt (
    .count_i (cnt),
    .wdata_o (bus_wdata_o)
  );

  // single full-width memory writes only
  assign bus_prio_o     = PRIO_TOP;
  assign bus_rnw_o      = 1'b0;
  assign bus_be_o       = '1;
  assign bus_size_o     = SIZE_WORD;
  assign bus_type_o     = TYPE_MEM;
  assign bus_lock_o     = 1'b0;
  assign bus_abort_o    = 1'b0;
  assign bus_compress_o = 1'b0;
  assign bus_guarded_o  = 1'b0;
  assign bus_ordered_o  = 1'b0;

  assign bus_req_o = (st == ST_REQ);
  assign busy_o    = (st == ST_REQ) || (st == ST_DATA) || (st == ST_NEXT);
  assign done_o    = (st == ST_DONE);
  assign err_o     = (st == ST_ERR);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !addr_ack_i && !bus_err_i) |=> bus_req_o); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && addr_ack_i) |=> !bus_req_o); // R4
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_req_o && !wr_ack_i && st == ST_DATA) |=> $stable(bus_wdata_o)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DATA && wr_ack_i && !bus_err_i) |=>
      (bus_addr_o == $past(bus_addr_o) + ADDR_W'(BE_W))); // R6
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && !bus_req_o)); // R7
  AST_ERR_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!bus_req_o && !done_o && !busy_o)); // R9
endmodule

// File: tb/tb_pattern_fill_master.sv
module tb_pattern_fill_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [31:0] wcnt = '0;
  logic        aack = 1'b0, wack = 1'b0, berr = 1'b0;
  logic        req, rnw, lock, abort, comp, guard, ord, busy, done, err;
  logic [1:0]  prio;
  logic [7:0]  be;
  logic [3:0]  size;
  logic [2:0]  typ;
  logic [31:0] addr;
  logic [63:0] wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  pattern_fill_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .word_count_i(wcnt), .addr_ack_i(aack), .wr_ack_i(wack), .bus_err_i(berr),
    .bus_req_o(req), .bus_prio_o(prio), .bus_rnw_o(rnw), .bus_be_o(be),
    .bus_size_o(size), .bus_type_o(typ), .bus_lock_o(lock), .bus_abort_o(abort),
    .bus_compress_o(comp), .bus_guarded_o(guard), .bus_ordered_o(ord),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [63:0] exp_data(input logic [31:0] k);
    return {k, ~k};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] k);
    return b + (k << 3);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic chk_attrs();
    logic [23:0] a, e;
    a = {prio, rnw, be, size, typ, lock, abort, comp, guard, ord};
    e = {2'b11, 1'b0, 8'hFF, 4'b0000, 3'b000, 5'b00000};
    chk(a == e, "R1 attributes", 64'(a), 64'(e));
  endtask

  task automatic pulse_start(input logic [31:0] b, input logic [31:0] n);
    base = b; wcnt = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_req(output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (req) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  // one beat from the slave side; inject = fire a stray start during data wait
  task automatic do_beat(input logic [31:0] b, input logic [31:0] k,
                         input int d1, input int d2, input bit inject);
    bit got;
    wait_req(got);
    chk(got, "R4 request rises", 64'(got), 64'd1);
    chk(addr == exp_addr(b, k), k == 0 ? "R3 first address" : "R6 beat address",
        64'(addr), 64'(exp_addr(b, k)));
    for (int i = 0; i < d1; i++) begin
      @(negedge clk);
      chk(req == 1'b1, "R4 request held", 64'(req), 64'd1);
    end
    aack = 1'b1;
    @(negedge clk);
    aack = 1'b0;
    chk(req == 1'b0 && busy, "R4 request dropped", 64'({req, busy}), 64'b01);
    chk(wdata == exp_data(k), "R5 write data", wdata, exp_data(k));
    if (inject) begin
      base = b ^ 32'h0010_0000; wcnt = 32'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!req && busy && wdata == exp_data(k), "R10 start ignored in fill",
          wdata, exp_data(k));
    end
    for (int i = 0; i < d2; i++) begin
      @(negedge clk);
      chk(wdata == exp_data(k) && addr == exp_addr(b, k), "R5 data held", wdata, exp_data(k));
    end
    wack = 1'b1;
    @(negedge clk);
    wack = 1'b0;
  endtask

  task automatic run_fill(input logic [31:0] b, input logic [31:0] n,
                          input int maxd, input int inject_at);
    pulse_start(b, n);
    for (int k = 0; k < int'(n); k++)
      do_beat(b, 32'(k), (maxd == 0) ? 0 : int'($urandom % (maxd + 1)),
              (maxd == 0) ? 0 : int'($urandom % (maxd + 1)), k == inject_at);
    @(negedge clk);
    chk(done && !req && !busy && !err, "R7 done after last beat",
        64'({done, req, busy, err}), 64'b1000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done && !req, "R7 no extra request", 64'({done, req}), 64'b10);
    end
    chk_attrs();
  endtask

  task automatic err_case(input bit in_data, input bit with_ack);
    bit got;
    pulse_start(32'h0000_4000, 32'd5);
    wait_req(got);
    if (in_data) begin
      aack = 1'b1; @(negedge clk); aack = 1'b0;
      wack = with_ack;
    end else begin
      aack = with_ack;
    end
    berr = 1'b1;
    @(negedge clk);
    berr = 1'b0; aack = 1'b0; wack = 1'b0;
    chk(err && !req && !done && !busy, in_data ? "R9 error in data phase" : "R9 error in request phase",
        64'({err, req, done, busy}), 64'b1000);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(err && !req, "R9 error flag held", 64'({err, req}), 64'b10);
    chk_attrs();
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done && !err, "R2 reset state", 64'({req, busy, done, err}), 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !busy && !done && !err, "R2 idle after reset", 64'({req, busy, done, err}), 64'b0);
    chk_attrs();

    // R8 zero length
    pulse_start(32'h0000_1000, 32'd0);
    chk(done && !req && !busy, "R8 zero count done", 64'({done, req, busy}), 64'b100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req, "R8 no request", 64'(req), 64'd0);
    end

    run_fill(32'h0000_2000, 32'd1, 0, -1);        // single word, zero wait
    run_fill(32'hFFFF_FFF0, 32'd4, 2, -1);        // address wrap
    run_fill(32'h0000_8000, 32'd6, 3, 2);         // R10 stray start mid-fill

    err_case(1'b0, 1'b0);
    err_case(1'b1, 1'b0);
    err_case(1'b0, 1'b1);                          // error beats address ack
    err_case(1'b1, 1'b1);                          // error beats data ack

    // restart from error clears flag (R9, R3)
    run_fill(32'h0001_0000, 32'd2, 1, -1);
    chk(!err, "R9 error cleared by start", 64'(err), 64'd0);

    for (int r = 0; r < 12; r++) begin
      logic [31:0] b;
      b = $urandom & 32'hFFFF_FFF8;
      run_fill(b, 32'(1 + ($urandom % 16)), 3, -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule